// File: doc/BRIEF.md
# Pipelined Integer Square Root

This block takes an unsigned radicand of 2N bits and returns its integer square root, the largest N-bit value whose square does not exceed the radicand. The remainder can also be returned. The datapath is a chain of N registered rows. Each row decides one root bit, starting with the most significant. To do this it moves the next pair of radicand bits into a running remainder and tries to subtract the partial root with binary 01 appended. If the subtraction produces no final borrow, the difference becomes the new remainder and the root bit is 1. If it does borrow, the old value passes through unchanged and the root bit is 0. No row ever adds a correction or goes back to change a bit it has already decided.

A row is built from single-bit cells, and each cell either subtracts or passes its input through. The borrow from the top of the row selects which one, for every cell in that row. Some cells see a constant trial bit: the two appended bits, and the positions above the root bits decided so far. Those cells are built as reduced variants. A new radicand can be presented every clock. The answer appears a fixed N clocks later, together with a strobe that follows the input strobe through the pipeline.

Top module: `isqrt_pipe`

## Requirements
- R1: A radicand presented with `in_valid_i` high in a cycle produces exactly one result, with `out_valid_o` high, N clock edges later. Results keep the order of their inputs, and a new input is accepted every cycle.
- R2: `root_o` is the largest value r such that r·r ≤ radicand.
- R3: When the remainder is produced, `rem_o` equals radicand − root·root. It is N+1 bits wide, and an exact square gives 0.
- R4: The produced remainder never exceeds 2·root.
- R5: Radicand 0 gives root 0 and remainder 0.
- R6: The all-ones radicand gives root 2^N − 1 and remainder 2^(N+1) − 2.
- R7: Every exact square k² gives root k and remainder 0, including k = 2^N − 1.
- R8: Radicand 93 gives root 9 and remainder 12.
- R9: With `REM_MODE` set to omit, `rem_o` always reads 0 and `root_o` is the same as in the producing variant.
- R10: While `rst_ni` is low, `out_valid_o` is 0 whatever the inputs are. After release it stays 0 until a radicand has been presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Radicand strobe |
| radicand_i | input | 2*ROOT_W | Unsigned radicand |
| out_valid_o | output | 1 | Result strobe |
| root_o | output | ROOT_W | Integer square root |
| rem_o | output | ROOT_W+1 | Remainder, or 0 when omitted |

## Verification
The properties assume that `in_valid_i` and `radicand_i` are sampled only on rising edges and are never unknown there. The checker keeps its own record of the valid strobe and of each radicand. It compares the root and the remainder against that record whenever a result leaves the pipeline. The bench changes inputs only on falling edges and always drives both of them to known values, including while reset is held. It mixes back-to-back issue with idle gaps, so the result strobe is exercised both in unbroken runs and with gaps.

// File: rtl/isqrt_pkg.sv
package isqrt_pkg;

    // Kind of trial bit seen by one cell of a row
    typedef enum logic [1:0] {
        Y_VAR  = 2'd0,
        Y_ZERO = 2'd1,
        Y_ONE  = 2'd2
    } ybit_e;

    // Whether the last row drives the remainder out
    typedef enum logic {
        REM_OMIT = 1'b0,
        REM_EMIT = 1'b1
    } rem_mode_e;

    // Trial word of row 'stage' is {partial root (stage bits), 2'b01}.
    // Bit 0 is always 1, bit 1 always 0, bits above the partial root are 0.
    function automatic ybit_e trial_bit_kind(int unsigned pos, int unsigned stage);
        if (pos == 0)         return Y_ONE;
        if (pos == 1)         return Y_ZERO;
        if (pos < stage + 2)  return Y_VAR;
        return Y_ZERO;
    endfunction

endpackage

// File: rtl/isqrt_csm_cell.sv
module isqrt_csm_cell
    import isqrt_pkg::*;
#(
    parameter ybit_e Y_KIND = Y_VAR
) (
    input  logic x_i,
    input  logic y_i,
    input  logic b_i,
    input  logic u_i,
    output logic d_o,
    output logic bo_o
);

    logic diff;

    generate
        if (Y_KIND == Y_VAR) begin : g_var
            always_comb begin
                diff = x_i ^ y_i ^ b_i;
                bo_o = (~x_i & y_i) | (~(x_i ^ y_i) & b_i);
            end
        end else if (Y_KIND == Y_ONE) begin : g_one
            logic unused_y;
            assign unused_y = y_i;
            always_comb begin
                diff = ~(x_i ^ b_i);
                bo_o = ~x_i | b_i;
            end
        end else begin : g_zero
            logic unused_y;
            assign unused_y = y_i;
            always_comb begin
                diff = x_i ^ b_i;
                bo_o = ~x_i & b_i;
            end
        end
    endgenerate

    // u = 1 keeps the minuend, u = 0 takes the difference
    assign d_o = u_i ? x_i : diff;

endmodule

// File: rtl/isqrt_stage.sv
module isqrt_stage
    import isqrt_pkg::*;
#(
    parameter int unsigned ROOT_W   = 16,
    parameter int unsigned STAGE    = 0,
    parameter bit          DROP_REM = 1'b0
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  v_i,
    input  logic [ROOT_W:0]       rem_i,
    input  logic [ROOT_W-1:0]     root_i,
    input  logic [2*ROOT_W-1:0]   rad_i,
    output logic                  v_o,
    output logic [ROOT_W:0]       rem_o,
    output logic [ROOT_W-1:0]     root_o,
    output logic [2*ROOT_W-1:0]   rad_o
);

    localparam int unsigned RADW = 2 * ROOT_W;
    localparam int unsigned RW   = ROOT_W + 3;

    typedef struct packed {
        logic                v;
        logic [ROOT_W:0]     rem;
        logic [ROOT_W-1:0]   root;
        logic [RADW-1:0]     rad;
    } stage_s;

    stage_s st_d, st_q;

    logic [RW-1:0] x_row;
    logic [RW-1:0] y_row;
    logic [RW-1:0] d_row;
    logic [RW:0]   bw;
    logic          fail;

    assign x_row = {rem_i, rad_i[RADW-1 -: 2]};
    assign y_row = {1'b0, root_i, 2'b01};
    assign bw[0] = 1'b0;
    assign fail  = bw[RW];

    generate
        for (genvar j = 0; j < RW; j++) begin : g_cell
            localparam ybit_e KIND = trial_bit_kind(j, STAGE);
            isqrt_csm_cell #(.Y_KIND(KIND)) u_cell (
                .x_i  (x_row[j]),
                .y_i  (y_row[j]),
                .b_i  (bw[j]),
                .u_i  (fail),
                .d_o  (d_row[j]),
                .bo_o (bw[j+1])
            );
        end
    endgenerate

    logic [1:0] unused_top;
    assign unused_top = d_row[RW-1 -: 2];

    always_comb begin
        st_d.v    = v_i;
        st_d.root = {root_i[ROOT_W-2:0], ~fail};
        st_d.rad  = {rad_i[RADW-3:0], 2'b00};
        st_d.rem  = DROP_REM ? '0 : d_row[ROOT_W:0];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign v_o    = st_q.v;
    assign rem_o  = st_q.rem;
    assign root_o = st_q.root;
    assign rad_o  = st_q.rad;

endmodule

// File: rtl/isqrt_pipe.sv
module isqrt_pipe
    import isqrt_pkg::*;
#(
    parameter int unsigned ROOT_W   = 16,
    parameter rem_mode_e   REM_MODE = REM_EMIT
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  in_valid_i,
    input  logic [2*ROOT_W-1:0]   radicand_i,
    output logic                  out_valid_o,
    output logic [ROOT_W-1:0]     root_o,
    output logic [ROOT_W:0]       rem_o
);

    localparam int unsigned RADW = 2 * ROOT_W;

    logic                v_l    [ROOT_W+1];
    logic [ROOT_W:0]     rem_l  [ROOT_W+1];
    logic [ROOT_W-1:0]   root_l [ROOT_W+1];
    logic [RADW-1:0]     rad_l  [ROOT_W+1];

    assign v_l[0]    = in_valid_i;
    assign rem_l[0]  = '0;
    assign root_l[0] = '0;
    assign rad_l[0]  = radicand_i;

    generate
        for (genvar s = 0; s < ROOT_W; s++) begin : g_stage
            localparam bit DROP = (s == ROOT_W - 1) && (REM_MODE == REM_OMIT);
            isqrt_stage #(
                .ROOT_W   (ROOT_W),
                .STAGE    (s),
                .DROP_REM (DROP)
            ) u_stage (
                .clk_i  (clk_i),
                .rst_ni (rst_ni),
                .v_i    (v_l[s]),
                .rem_i  (rem_l[s]),
                .root_i (root_l[s]),
                .rad_i  (rad_l[s]),
                .v_o    (v_l[s+1]),
                .rem_o  (rem_l[s+1]),
                .root_o (root_l[s+1]),
                .rad_o  (rad_l[s+1])
            );
        end
    endgenerate

    logic [RADW-1:0] unused_rad;
    assign unused_rad = rad_l[ROOT_W];

    assign out_valid_o = v_l[ROOT_W];
    assign root_o      = root_l[ROOT_W];
    assign rem_o       = rem_l[ROOT_W];

endmodule

// File: rtl/isqrt_pipe_chk.sv
module isqrt_pipe_chk
    import isqrt_pkg::*;
#(
    parameter int unsigned ROOT_W   = 16,
    parameter rem_mode_e   REM_MODE = REM_EMIT
) (
    input logic                  clk_i,
    input logic                  rst_ni,
    input logic                  in_valid_i,
    input logic [2*ROOT_W-1:0]   radicand_i,
    input logic                  out_valid_o,
    input logic [ROOT_W-1:0]     root_o,
    input logic [ROOT_W:0]       rem_o
);

    localparam int unsigned RADW = 2 * ROOT_W;
    localparam int unsigned WW   = RADW + 2;

    logic [ROOT_W-1:0] vld_sr;
    logic [RADW-1:0]   rad_sr [ROOT_W];

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            vld_sr <= '0;
            for (int i = 0; i < ROOT_W; i++) rad_sr[i] <= '0;
        end else begin
            vld_sr    <= {vld_sr[ROOT_W-2:0], in_valid_i};
            rad_sr[0] <= radicand_i;
            for (int i = 1; i < ROOT_W; i++) rad_sr[i] <= rad_sr[i-1];
        end
    end

    logic [WW-1:0] rad_w, sq_lo, sq_hi, root_w, rem_w;

    always_comb begin
        rad_w  = WW'(rad_sr[ROOT_W-1]);
        root_w = WW'(root_o);
        sq_lo  = root_w * root_w;
        sq_hi  = (root_w + 1) * (root_w + 1);
        rem_w  = WW'(rem_o);
    end

    // R1: strobe emerges exactly ROOT_W edges after entry
    p_latency_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        out_valid_o == vld_sr[ROOT_W-1]);

    // R2: root is the floor of the square root
    p_root_floor_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        out_valid_o |-> (sq_lo <= rad_w) && (rad_w < sq_hi));

    generate
        if (REM_MODE == REM_EMIT) begin : g_rem
            // R3: remainder closes the identity
            p_rem_identity_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
                out_valid_o |-> rem_w == rad_w - sq_lo);
            // R4: remainder bounded by twice the root
            p_rem_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
                out_valid_o |-> rem_w <= (root_w << 1));
            // R7: exact squares leave nothing
            p_exact_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (out_valid_o && rad_w == sq_lo) |-> rem_o == '0);
        end else begin : g_norem
            logic unused_rem;
            assign unused_rem = ^rem_w;
        end
    endgenerate

endmodule

bind isqrt_pipe isqrt_pipe_chk #(.ROOT_W(ROOT_W), .REM_MODE(REM_MODE)) chk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .radicand_i  (radicand_i),
    .out_valid_o (out_valid_o),
    .root_o      (root_o),
    .rem_o       (rem_o)
);

// File: tb/isqrt_pipe_tb.sv
module isqrt_pipe_tb_top;
    import isqrt_pkg::*;

    localparam int unsigned N    = 16;
    localparam int unsigned RADW = 2 * N;

    logic            clk_i = 1'b0;
    logic            rst_ni;
    logic            in_valid;
    logic [RADW-1:0] rad;
    logic            out_valid, out_valid_nr;
    logic [N-1:0]    root, root_nr;
    logic [N:0]      rem, rem_nr;

    always #2 clk_i = ~clk_i;   // 250 MHz

    isqrt_pipe #(.ROOT_W(N), .REM_MODE(REM_EMIT)) dut_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid), .radicand_i(rad),
        .out_valid_o(out_valid), .root_o(root), .rem_o(rem));

    isqrt_pipe #(.ROOT_W(N), .REM_MODE(REM_OMIT)) dut_norem_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid), .radicand_i(rad),
        .out_valid_o(out_valid_nr), .root_o(root_nr), .rem_o(rem_nr));

    typedef struct {
        int unsigned     due;
        logic [RADW-1:0] rad;
        logic [N-1:0]    root;
        logic [N:0]      rem;
        string           tag;
    } exp_t;

    exp_t        sb[$];
    int unsigned cyc = 0;
    int unsigned n_checks = 0;
    int unsigned n_err = 0;
    bit          done = 1'b0;

    always @(posedge clk_i) cyc <= cyc + 1;

    function automatic longint unsigned ref_root(longint unsigned r);
        longint unsigned lo = 0;
        longint unsigned hi = longint'(1) << N;
        while (hi - lo > 1) begin
            longint unsigned mid = (lo + hi) / 2;
            if (mid * mid <= r) lo = mid;
            else hi = mid;
        end
        return lo;
    endfunction

    task automatic check(bit ok, string tag, string what, longint act, longint exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic send(logic [RADW-1:0] r, string tag);
        exp_t e;
        longint unsigned q;
        @(negedge clk_i);
        in_valid = 1'b1;
        rad      = r;
        q        = ref_root(longint'(r));
        e.due    = cyc + N;
        e.rad    = r;
        e.root   = N'(q);
        e.rem    = (N+1)'(longint'(r) - q * q);
        e.tag    = tag;
        sb.push_back(e);
    endtask

    task automatic idle(int unsigned n);
        for (int i = 0; i < int'(n); i++) begin
            @(negedge clk_i);
            in_valid = 1'b0;
        end
    endtask

    // Scoreboard monitor
    always @(negedge clk_i) begin
        if (rst_ni && !done) begin
            if (out_valid) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R1", "unexpected result", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(cyc == e.due, "R1", "result cycle", cyc, e.due);
                    check(root == e.root, e.tag, "root", root, e.root);
                    check(rem == e.rem, (e.tag == "R2") ? "R3" : e.tag, "remainder", rem, e.rem);
                    check({1'b0, rem} <= {root, 1'b0}, "R4", "remainder bound", rem, {root, 1'b0});
                    check(out_valid_nr && root_nr == e.root, "R9", "omit-variant root", root_nr, e.root);
                    check(rem_nr == '0, "R9", "omit-variant remainder", rem_nr, 0);
                end
            end else if (sb.size() != 0 && sb[0].due == cyc) begin
                check(1'b0, "R1", "missing result", 0, 1);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk_i);
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog expired, %0d results outstanding", sb.size());
            $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        logic [31:0] lfsr;
        rst_ni   = 1'b0;
        in_valid = 1'b1;            // R10: strobe held high during reset
        rad      = 32'd93;
        repeat (N + 3) @(negedge clk_i);
        check(out_valid == 1'b0, "R10", "valid during reset", out_valid, 0);
        in_valid = 1'b0;
        rad      = '0;
        @(negedge clk_i);
        rst_ni = 1'b1;
        for (int i = 0; i < int'(N) + 2; i++) begin
            @(negedge clk_i);
            check(out_valid == 1'b0, "R10", "valid after release", out_valid, 0);
        end

        // Corner values
        send(32'd0, "R5");
        send(32'hFFFF_FFFF, "R6");
        send(32'd93, "R8");
        idle(3);
        send(32'd1, "R7");
        send(32'd4, "R7");
        send(32'd144, "R7");
        send(32'hFFFE_0001, "R7");   // 65535 squared
        send(32'd3, "R2");
        send(32'd8, "R2");
        idle(N + 2);

        // Small sweep, back to back
        for (int v = 0; v < 48; v++) send(32'(v), "R2");
        idle(2);

        // Squares and their neighbours
        for (int k = 2; k < 65536; k = k * 3 + 1) begin
            send(32'(k * k), "R7");
            send(32'(k * k - 1), "R2");
            send(32'(k * k + 2 * k), "R2");
        end
        idle(1);

        // Pseudo-random stream with gaps
        lfsr = 32'h1234_5678;
        for (int i = 0; i < 400; i++) begin
            lfsr = lfsr ^ (lfsr << 13);
            lfsr = lfsr ^ (lfsr >> 17);
            lfsr = lfsr ^ (lfsr << 5);
            send(lfsr, "R2");
            if (lfsr[3:0] == 4'd0) idle(32'(lfsr[5:4]) + 1);
        end
        idle(1);

        while (sb.size() != 0) @(negedge clk_i);
        idle(4);
        check(out_valid == 1'b0, "R1", "idle after drain", out_valid, 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

endmodule